// File: doc/BRIEF.md
# Interrupt Source Controller

This block keeps the per-source state of a bank of interrupt sources numbered from a fixed base. Every source has a destination server, a delivery priority, a remembered priority used by disable and enable, a type chosen at build time (edge or level), and four status flags: bounced, in-flight, input-high and held-while-masked. Edge sources fire on a one-cycle pulse. Level sources follow a held input. In both cases the block decides whether the source may be handed to the presentation side and, if so, presents it on a single offer port.

The presentation side sends back rejects, end-of-interrupt notices and resend requests. A resend walks the sources one per cycle and re-presents those that were bounced or that are level sources ready for delivery again. Software-facing commands set the route and priority, read them back, disable a source or enable it again. Each command gets a response one cycle later. Priority 0xFF means masked throughout.

Top module: `irq_source_ctl`

## Requirements
- R1: A command naming a number outside BASE to BASE+NUM_SRC-1 responds with rspErr=1. A set command (cmdOp=0) with cmdServer >= NUM_SERVERS or cmdPrio above 0xFF also responds with rspErr=1. A command that errors changes no state.
- R2: After reset every source has priority 0xFF, saved priority 0xFF and server 0, all status flags are clear, and no offer or response is active.
- R3: An edge pulse on a source whose priority is 0xFF marks it held-while-masked and produces no offer. Otherwise the source is offered with its server and priority.
- R4: A level source is offered only when its priority is not 0xFF, its input is high and it is not already in flight. Offering it sets the in-flight flag, so a held input gives one offer.
- R5: A reject naming a source marks it bounced and clears its in-flight flag. The source is not re-offered before a resend.
- R6: A resend (resendReq) visits every source, one per cycle, and pauses while an offer waits unaccepted. A level source is re-evaluated under R4. A bounced edge source has its bounced flag cleared and is offered again if its priority is not 0xFF.
- R7: An end-of-interrupt clears the in-flight flag of a level source and does not offer it by itself. It has no effect on an edge source.
- R8: A set command (cmdOp=0) writes server, priority and saved priority. A held-while-masked edge source given a priority other than 0xFF is then offered. A level source is re-evaluated under R4.
- R9: Disable (cmdOp=2) writes priority 0xFF and copies the old priority into the saved priority. Enable (cmdOp=3) writes the saved priority back as the priority, with the same follow-up as R8.
- R10: An offer stays stable on offNum, offServer and offPrio until offReady is seen. When several sources wait, the lowest-numbered one is offered first. An offer never carries priority 0xFF.
- R11: Every command gets rspValid exactly one cycle later. A read (cmdOp=1) returns the stored server and priority. Other commands return zeros in those fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| edgeFire | input | NUM_SRC | One-cycle fire pulses, one per source (edge sources) |
| lvlIn | input | NUM_SRC | Held input lines, one per source (level sources) |
| rejValid | input | 1 | Reject strobe from the presentation side |
| rejNum | input | NUM_W | Source number being rejected |
| eoiValid | input | 1 | End-of-interrupt strobe |
| eoiNum | input | NUM_W | Source number being completed |
| resendReq | input | 1 | Starts, or restarts, a resend scan |
| offReady | input | 1 | Presentation side takes the current offer |
| offValid | output | 1 | An offer is presented |
| offNum | output | NUM_W | Offered source number |
| offServer | output | SRV_W | Destination server of the offer |
| offPrio | output | 8 | Priority of the offer |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 2 | 0 set, 1 read, 2 disable, 3 enable |
| cmdNum | input | NUM_W | Source number addressed by the command |
| cmdServer | input | SRV_W | Server for a set command |
| cmdPrio | input | 9 | Priority for a set command (values above 0xFF are errors) |
| rspValid | output | 1 | Command response strobe |
| rspErr | output | 1 | Parameter error |
| rspServer | output | SRV_W | Server returned by a read |
| rspPrio | output | 8 | Priority returned by a read |

## Verification
The hold check on the offer port assumes the presentation side keeps each offer in view until it raises offReady. The masked-fire check assumes edge pulses last one cycle. The bench changes every input at the falling edge and keeps offReady low except for single-cycle acceptances. It sends rejects and end-of-interrupt notices only for numbers that have been offered, and it lets each resend scan run out before it judges whether an offer is absent.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

  // Index fields in the strobe struct are sized for up to 256 sources.
  localparam int IDX_CAP_W = 8;
  localparam logic [7:0] PRIO_MASKED = 8'hFF;

  typedef enum logic [1:0] {
    OP_SET = 2'd0,
    OP_GET = 2'd1,
    OP_OFF = 2'd2,
    OP_ON  = 2'd3
  } cmd_op_e;

  // Strobes from the sequencer to the per-source state.
  typedef struct packed {
    logic                 loadEn;   // source loadIdx moves into the offer register
    logic [IDX_CAP_W-1:0] loadIdx;
    logic                 scanEn;   // resend scan visits scanIdx this cycle
    logic [IDX_CAP_W-1:0] scanIdx;
    logic                 wrEn;     // command write to wrIdx
    logic [IDX_CAP_W-1:0] wrIdx;
    logic [7:0]           wrPrio;
    logic [7:0]           wrSaved;
  } src_strobe_t;

endpackage

// File: rtl/irq_src_state.sv
module irq_src_state
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int BASE    = 16,
  parameter int NUM_W   = 10,
  parameter int SRV_W   = 2,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  src_strobe_t          strb,
  input  logic [SRV_W-1:0]     wrSrv,
  input  logic [NUM_SRC-1:0]   edgeFire,
  input  logic [NUM_SRC-1:0]   lvlIn,
  input  logic                 rejValid,
  input  logic [NUM_W-1:0]     rejNum,
  input  logic                 eoiValid,
  input  logic [NUM_W-1:0]     eoiNum,
  input  logic [IDX_CAP_W-1:0] rdIdx,
  output logic [SRV_W-1:0]     rdSrv,
  output logic [7:0]           rdPrio,
  output logic [7:0]           rdSaved,
  output logic                 reqAny,
  output logic [IDX_CAP_W-1:0] reqIdx,
  output logic [SRV_W-1:0]     reqSrv,
  output logic [7:0]           reqPrio
);

  localparam logic [NUM_W-1:0] LO_NUM = NUM_W'(BASE);
  localparam logic [NUM_W-1:0] HI_NUM = NUM_W'(BASE + NUM_SRC);

  logic                 rejOk, eoiOk;
  logic [IDX_CAP_W-1:0] rejIdx, eoiIdx;

  assign rejOk  = rejValid && (rejNum >= LO_NUM) && (rejNum < HI_NUM);
  assign eoiOk  = eoiValid && (eoiNum >= LO_NUM) && (eoiNum < HI_NUM);
  assign rejIdx = IDX_CAP_W'(rejNum - LO_NUM);
  assign eoiIdx = IDX_CAP_W'(eoiNum - LO_NUM);

  logic [NUM_SRC-1:0][SRV_W-1:0] srvArr;
  logic [NUM_SRC-1:0][7:0]       prioArr;
  logic [NUM_SRC-1:0][7:0]       savedArr;
  logic [NUM_SRC-1:0]            reqVec;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam bit IS_LVL = LEVEL_MASK[i];
    localparam logic [IDX_CAP_W-1:0] MY_IDX = IDX_CAP_W'(i);

    logic [SRV_W-1:0] srvQ, srvD;
    logic [7:0]       prioQ, prioD, savedQ, savedD;
    logic             rejQ, rejD, sentQ, sentD, asrtQ, asrtD, mpQ, mpD, qdQ, qdD;
    logic             recheck;
    logic             wrHit, loadHit, scanHit, rejHit, eoiHit;

    assign wrHit   = strb.wrEn   && (strb.wrIdx   == MY_IDX);
    assign loadHit = strb.loadEn && (strb.loadIdx == MY_IDX);
    assign scanHit = strb.scanEn && (strb.scanIdx == MY_IDX);
    assign rejHit  = rejOk && (rejIdx == MY_IDX);
    assign eoiHit  = eoiOk && (eoiIdx == MY_IDX);

    always_comb begin
      srvD    = srvQ;
      prioD   = prioQ;
      savedD  = savedQ;
      rejD    = rejQ;
      sentD   = sentQ;
      asrtD   = asrtQ;
      mpD     = mpQ;
      qdD     = qdQ;
      recheck = 1'b0;

      // Moving into the offer register consumes the queued request.
      if (loadHit) qdD = 1'b0;

      if (wrHit) begin
        srvD   = wrSrv;
        prioD  = strb.wrPrio;
        savedD = strb.wrSaved;
        if (IS_LVL) begin
          recheck = 1'b1;
          if (qdD && strb.wrPrio == PRIO_MASKED) begin
            qdD   = 1'b0;
            sentD = 1'b0;
          end
        end else begin
          if (mpD && strb.wrPrio != PRIO_MASKED) begin
            mpD = 1'b0;
            qdD = 1'b1;
          end else if (qdD && strb.wrPrio == PRIO_MASKED) begin
            qdD = 1'b0;
            mpD = 1'b1;
          end
        end
      end

      if (rejHit) begin
        rejD  = 1'b1;
        sentD = 1'b0;
      end

      if (eoiHit && IS_LVL) sentD = 1'b0;

      if (IS_LVL) begin
        asrtD = lvlIn[i];
        if (lvlIn[i] != asrtQ) recheck = 1'b1;
      end else if (edgeFire[i]) begin
        if (prioD == PRIO_MASKED) mpD = 1'b1;
        else                      qdD = 1'b1;
      end

      if (scanHit) begin
        if (IS_LVL) begin
          recheck = 1'b1;
        end else if (rejD) begin
          rejD = 1'b0;
          if (prioD != PRIO_MASKED) qdD = 1'b1;
        end
      end

      if (IS_LVL && recheck && prioD != PRIO_MASKED && asrtD && !sentD) begin
        sentD = 1'b1;
        qdD   = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        srvQ   <= '0;
        prioQ  <= PRIO_MASKED;
        savedQ <= PRIO_MASKED;
        rejQ   <= 1'b0;
        sentQ  <= 1'b0;
        asrtQ  <= 1'b0;
        mpQ    <= 1'b0;
        qdQ    <= 1'b0;
      end else begin
        srvQ   <= srvD;
        prioQ  <= prioD;
        savedQ <= savedD;
        rejQ   <= rejD;
        sentQ  <= sentD;
        asrtQ  <= asrtD;
        mpQ    <= mpD;
        qdQ    <= qdD;
      end
    end

    assign srvArr[i]   = srvQ;
    assign prioArr[i]  = prioQ;
    assign savedArr[i] = savedQ;
    assign reqVec[i]   = qdQ && (prioQ != PRIO_MASKED);

    if (!IS_LVL) begin : g_edgeChk
      // R3: a fire on a masked edge source is remembered, not offered
      assert_masked_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        edgeFire[i] && (prioQ == PRIO_MASKED) && !wrHit |=> mpQ && !qdQ);
    end
  end

  // Lowest index wins: scan from the top so the lowest hit is written last.
  always_comb begin
    reqAny  = 1'b0;
    reqIdx  = '0;
    reqSrv  = '0;
    reqPrio = PRIO_MASKED;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (reqVec[i]) begin
        reqAny  = 1'b1;
        reqIdx  = IDX_CAP_W'(i);
        reqSrv  = srvArr[i];
        reqPrio = prioArr[i];
      end
    end
  end

  always_comb begin
    rdSrv   = '0;
    rdPrio  = PRIO_MASKED;
    rdSaved = PRIO_MASKED;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (rdIdx == IDX_CAP_W'(i)) begin
        rdSrv   = srvArr[i];
        rdPrio  = prioArr[i];
        rdSaved = savedArr[i];
      end
    end
  end

endmodule

// File: rtl/irq_src_seq.sv
module irq_src_seq
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int BASE        = 16,
  parameter int NUM_W       = 10,
  parameter int SRV_W       = 2,
  parameter int NUM_SERVERS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmdValid,
  input  logic [1:0]           cmdOp,
  input  logic [NUM_W-1:0]     cmdNum,
  input  logic [SRV_W-1:0]     cmdServer,
  input  logic [8:0]           cmdPrio,
  input  logic                 resendReq,
  input  logic                 offReady,
  input  logic                 reqAny,
  input  logic [IDX_CAP_W-1:0] reqIdx,
  input  logic [SRV_W-1:0]     reqSrv,
  input  logic [7:0]           reqPrio,
  input  logic [SRV_W-1:0]     rdSrv,
  input  logic [7:0]           rdPrio,
  input  logic [7:0]           rdSaved,
  output src_strobe_t          strb,
  output logic [SRV_W-1:0]     wrSrv,
  output logic [IDX_CAP_W-1:0] rdIdx,
  output logic                 offValid,
  output logic [NUM_W-1:0]     offNum,
  output logic [SRV_W-1:0]     offServer,
  output logic [7:0]           offPrio,
  output logic                 rspValid,
  output logic                 rspErr,
  output logic [SRV_W-1:0]     rspServer,
  output logic [7:0]           rspPrio
);

  localparam logic [NUM_W-1:0]     LO_NUM  = NUM_W'(BASE);
  localparam logic [NUM_W-1:0]     HI_NUM  = NUM_W'(BASE + NUM_SRC);
  localparam logic [SRV_W:0]       SRV_LIM = (SRV_W + 1)'(NUM_SERVERS);
  localparam logic [IDX_CAP_W-1:0] LAST_IX = IDX_CAP_W'(NUM_SRC - 1);

  cmd_op_e              op;
  logic                 numOk, srvOk, prioOk, cmdErr, slotFree;
  logic                 scanOn;
  logic [IDX_CAP_W-1:0] scanIdx;

  assign op       = cmd_op_e'(cmdOp);
  assign numOk    = (cmdNum >= LO_NUM) && (cmdNum < HI_NUM);
  assign srvOk    = {1'b0, cmdServer} < SRV_LIM;
  assign prioOk   = !cmdPrio[8];
  assign cmdErr   = !numOk || ((op == OP_SET) && !(srvOk && prioOk));
  assign rdIdx    = IDX_CAP_W'(cmdNum - LO_NUM);
  assign slotFree = !offValid || offReady;

  always_comb begin
    strb         = '0;
    strb.loadEn  = reqAny && slotFree;
    strb.loadIdx = reqIdx;
    strb.scanEn  = scanOn && slotFree;
    strb.scanIdx = scanIdx;
    strb.wrEn    = cmdValid && !cmdErr && (op != OP_GET);
    strb.wrIdx   = rdIdx;
    wrSrv        = rdSrv;
    case (op)
      OP_SET: begin
        wrSrv        = cmdServer;
        strb.wrPrio  = cmdPrio[7:0];
        strb.wrSaved = cmdPrio[7:0];
      end
      OP_OFF: begin
        strb.wrPrio  = PRIO_MASKED;
        strb.wrSaved = rdPrio;
      end
      OP_ON: begin
        strb.wrPrio  = rdSaved;
        strb.wrSaved = rdSaved;
      end
      default: begin
        strb.wrPrio  = rdPrio;
        strb.wrSaved = rdSaved;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offValid  <= 1'b0;
      offNum    <= '0;
      offServer <= '0;
      offPrio   <= '0;
      scanOn    <= 1'b0;
      scanIdx   <= '0;
      rspValid  <= 1'b0;
      rspErr    <= 1'b0;
      rspServer <= '0;
      rspPrio   <= '0;
    end else begin
      if (slotFree) begin
        offValid <= reqAny;
        if (reqAny) begin
          offNum    <= NUM_W'(reqIdx) + LO_NUM;
          offServer <= reqSrv;
          offPrio   <= reqPrio;
        end
      end

      if (resendReq) begin
        scanOn  <= 1'b1;
        scanIdx <= '0;
      end else if (strb.scanEn) begin
        if (scanIdx == LAST_IX) scanOn <= 1'b0;
        else                    scanIdx <= scanIdx + 1'b1;
      end

      rspValid <= cmdValid;
      rspErr   <= cmdValid && cmdErr;
      if (cmdValid && !cmdErr && (op == OP_GET)) begin
        rspServer <= rdSrv;
        rspPrio   <= rdPrio;
      end else begin
        rspServer <= '0;
        rspPrio   <= '0;
      end
    end
  end

  // R10: an unaccepted offer does not move
  assert_offer_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    offValid && !offReady |=> offValid && $stable(offNum) && $stable(offServer) && $stable(offPrio));

  // R10: masked priority never reaches the offer port
  assert_offer_unmasked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    offValid |-> offPrio != PRIO_MASKED);

  // R11: one response per command, one cycle later
  assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid |=> rspValid);
  assert_rsp_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmdValid |=> !rspValid);

  // R1: an out-of-range number always errors
  assert_bad_num_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid && ((cmdNum < LO_NUM) || (cmdNum >= HI_NUM)) |=> rspErr);

  // R6: the scan pauses while an offer waits
  assert_scan_pause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    scanOn && offValid && !offReady && !resendReq |=> scanOn && $stable(scanIdx));

endmodule

// File: rtl/irq_source_ctl.sv
module irq_source_ctl
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int BASE        = 16,
  parameter int NUM_W       = 10,
  parameter int SRV_W       = 2,
  parameter int NUM_SERVERS = 3,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK =
    {{(NUM_SRC - NUM_SRC/2){1'b1}}, {(NUM_SRC/2){1'b0}}}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] edgeFire,
  input  logic [NUM_SRC-1:0] lvlIn,
  input  logic               rejValid,
  input  logic [NUM_W-1:0]   rejNum,
  input  logic               eoiValid,
  input  logic [NUM_W-1:0]   eoiNum,
  input  logic               resendReq,
  input  logic               offReady,
  output logic               offValid,
  output logic [NUM_W-1:0]   offNum,
  output logic [SRV_W-1:0]   offServer,
  output logic [7:0]         offPrio,
  input  logic               cmdValid,
  input  logic [1:0]         cmdOp,
  input  logic [NUM_W-1:0]   cmdNum,
  input  logic [SRV_W-1:0]   cmdServer,
  input  logic [8:0]         cmdPrio,
  output logic               rspValid,
  output logic               rspErr,
  output logic [SRV_W-1:0]   rspServer,
  output logic [7:0]         rspPrio
);

  src_strobe_t          strb;
  logic [SRV_W-1:0]     wrSrv, rdSrv, reqSrv;
  logic [IDX_CAP_W-1:0] rdIdx, reqIdx;
  logic [7:0]           rdPrio, rdSaved, reqPrio;
  logic                 reqAny;

  irq_src_state #(
    .NUM_SRC(NUM_SRC), .BASE(BASE), .NUM_W(NUM_W), .SRV_W(SRV_W), .LEVEL_MASK(LEVEL_MASK)
  ) u_state (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrSrv(wrSrv),
    .edgeFire(edgeFire), .lvlIn(lvlIn),
    .rejValid(rejValid), .rejNum(rejNum), .eoiValid(eoiValid), .eoiNum(eoiNum),
    .rdIdx(rdIdx), .rdSrv(rdSrv), .rdPrio(rdPrio), .rdSaved(rdSaved),
    .reqAny(reqAny), .reqIdx(reqIdx), .reqSrv(reqSrv), .reqPrio(reqPrio)
  );

  irq_src_seq #(
    .NUM_SRC(NUM_SRC), .BASE(BASE), .NUM_W(NUM_W), .SRV_W(SRV_W), .NUM_SERVERS(NUM_SERVERS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdNum(cmdNum), .cmdServer(cmdServer), .cmdPrio(cmdPrio),
    .resendReq(resendReq), .offReady(offReady),
    .reqAny(reqAny), .reqIdx(reqIdx), .reqSrv(reqSrv), .reqPrio(reqPrio),
    .rdSrv(rdSrv), .rdPrio(rdPrio), .rdSaved(rdSaved),
    .strb(strb), .wrSrv(wrSrv), .rdIdx(rdIdx),
    .offValid(offValid), .offNum(offNum), .offServer(offServer), .offPrio(offPrio),
    .rspValid(rspValid), .rspErr(rspErr), .rspServer(rspServer), .rspPrio(rspPrio)
  );

endmodule

// File: tb/irq_source_ctl_bench.sv
`timescale 1ns/1ps
module irq_source_ctl_bench;

  localparam int NUM_SRC = 8;
  localparam int NUM_W   = 10;
  localparam int SRV_W   = 2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NUM_SRC-1:0] edgeFire = '0;
  logic [NUM_SRC-1:0] lvlIn = '0;
  logic               rejValid = 1'b0, eoiValid = 1'b0, resendReq = 1'b0, offReady = 1'b0;
  logic [NUM_W-1:0]   rejNum = '0, eoiNum = '0;
  logic               cmdValid = 1'b0;
  logic [1:0]         cmdOp = '0;
  logic [NUM_W-1:0]   cmdNum = '0;
  logic [SRV_W-1:0]   cmdServer = '0;
  logic [8:0]         cmdPrio = '0;
  logic               offValid, rspValid, rspErr;
  logic [NUM_W-1:0]   offNum;
  logic [SRV_W-1:0]   offServer, rspServer;
  logic [7:0]         offPrio, rspPrio;

  int  nChecks = 0;
  int  nFail   = 0;
  bit  done    = 1'b0;

  always #2 clk = ~clk;

  irq_source_ctl u_irq_source_ctl (
    .clk(clk), .rst_n(rst_n), .edgeFire(edgeFire), .lvlIn(lvlIn),
    .rejValid(rejValid), .rejNum(rejNum), .eoiValid(eoiValid), .eoiNum(eoiNum),
    .resendReq(resendReq), .offReady(offReady),
    .offValid(offValid), .offNum(offNum), .offServer(offServer), .offPrio(offPrio),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdNum(cmdNum), .cmdServer(cmdServer), .cmdPrio(cmdPrio),
    .rspValid(rspValid), .rspErr(rspErr), .rspServer(rspServer), .rspPrio(rspPrio)
  );

  // op: 0 set, 1 read, 2 disable, 3 enable; valid numbers 16..23; servers 0..2
  typedef struct packed {
    int op; int num; int srv; int prio; int err; int esrv; int eprio; int req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1, 16, 0, 0,     0, 0, 255, 2},   // R2 reset priority
    '{1, 23, 0, 0,     0, 0, 255, 2},   // R2 last source
    '{1, 15, 0, 0,     1, 0, 0,   1},   // R1 below range
    '{1, 24, 0, 0,     1, 0, 0,   1},   // R1 above range
    '{0, 17, 2, 5,     0, 0, 0,   8},   // R8 set route
    '{1, 17, 0, 0,     0, 2, 5,   11},  // R11 read back
    '{0, 17, 3, 5,     1, 0, 0,   1},   // R1 server out of range
    '{0, 17, 1, 256,   1, 0, 0,   1},   // R1 priority above 0xFF
    '{1, 17, 0, 0,     0, 2, 5,   1},   // R1 no change after errors
    '{2, 17, 0, 0,     0, 0, 0,   9},   // R9 disable
    '{1, 17, 0, 0,     0, 2, 255, 9},   // R9 masked after disable
    '{3, 17, 0, 0,     0, 0, 0,   9},   // R9 enable
    '{1, 17, 0, 0,     0, 2, 5,   9},   // R9 restored
    '{2, 24, 0, 0,     1, 0, 0,   1}    // R1 disable out of range
  };

  task automatic checkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doCmd(input int op, input int num, input int srv, input int prio);
    cmdValid = 1'b1; cmdOp = 2'(op); cmdNum = NUM_W'(num);
    cmdServer = SRV_W'(srv); cmdPrio = 9'(prio);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic fire(input int idx);
    edgeFire[idx] = 1'b1;
    @(negedge clk);
    edgeFire = '0;
  endtask

  task automatic reject(input int num);
    rejValid = 1'b1; rejNum = NUM_W'(num);
    @(negedge clk);
    rejValid = 1'b0;
  endtask

  task automatic eoi(input int num);
    eoiValid = 1'b1; eoiNum = NUM_W'(num);
    @(negedge clk);
    eoiValid = 1'b0;
  endtask

  task automatic resend();
    resendReq = 1'b1;
    @(negedge clk);
    resendReq = 1'b0;
  endtask

  task automatic expectOffer(input string tag, input int num, input int srv, input int prio,
                             input bit take);
    int n = 0;
    while (!offValid && n < 24) begin
      @(negedge clk);
      n++;
    end
    checkEq({tag, " offValid"}, int'(offValid), 1);
    checkEq({tag, " offNum"}, int'(offNum), num);
    checkEq({tag, " offServer"}, int'(offServer), srv);
    checkEq({tag, " offPrio"}, int'(offPrio), prio);
    repeat (2) @(negedge clk);
    checkEq({tag, " R10 held offNum"}, int'(offNum), num);
    if (take) begin
      offReady = 1'b1;
      @(negedge clk);
      offReady = 1'b0;
    end
  endtask

  task automatic expectNone(input string tag);
    repeat (14) @(negedge clk);
    checkEq({tag, " no offer"}, int'(offValid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkEq("R2 reset offValid", int'(offValid), 0);
    checkEq("R2 reset rspValid", int'(rspValid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    checkEq("R2 after reset offValid", int'(offValid), 0);

    // command table
    for (int k = 0; k < NV; k++) begin
      doCmd(VEC[k].op, VEC[k].num, VEC[k].srv, VEC[k].prio);
      checkEq($sformatf("R11 vec%0d (R%0d) rspValid", k, VEC[k].req), int'(rspValid), 1);
      checkEq($sformatf("vec%0d (R%0d) rspErr", k, VEC[k].req), int'(rspErr), VEC[k].err);
      checkEq($sformatf("vec%0d (R%0d) rspServer", k, VEC[k].req), int'(rspServer), VEC[k].esrv);
      checkEq($sformatf("vec%0d (R%0d) rspPrio", k, VEC[k].req), int'(rspPrio), VEC[k].eprio);
      @(negedge clk);
      checkEq($sformatf("R11 vec%0d single response", k), int'(rspValid), 0);
    end

    // R3: masked edge fire, then R8 release by set
    fire(0);
    expectNone("R3 masked fire");
    doCmd(0, 16, 1, 3);
    expectOffer("R8 masked-pending release", 16, 1, 3, 1'b1);

    // R3: plain edge fire
    fire(1);
    expectOffer("R3 edge fire", 17, 2, 5, 1'b1);

    // R10: two at once, lowest first
    doCmd(0, 18, 0, 7);
    edgeFire = 8'b0000_0110;
    @(negedge clk);
    edgeFire = '0;
    expectOffer("R10 lowest first", 17, 2, 5, 1'b1);
    expectOffer("R10 second", 18, 0, 7, 1'b1);

    // R5 reject, R6 resend re-offer
    reject(17);
    expectNone("R5 reject waits for resend");
    resend();
    expectOffer("R6 resend bounced edge", 17, 2, 5, 1'b1);

    // R7 EOI on edge has no effect
    fire(1);
    expectOffer("R3 edge fire again", 17, 2, 5, 1'b1);
    eoi(17);
    resend();
    expectNone("R7 edge EOI no effect");

    // R4 level source 20
    doCmd(0, 20, 1, 2);
    expectNone("R4 level low");
    lvlIn[4] = 1'b1;
    expectOffer("R4 level rise", 20, 1, 2, 1'b1);
    expectNone("R4 level held once");
    resend();
    expectNone("R4 in flight blocks resend");
    eoi(20);
    expectNone("R7 EOI alone no offer");
    resend();
    expectOffer("R7 EOI then resend", 20, 1, 2, 1'b1);
    reject(20);
    resend();
    expectOffer("R5 level reject resend", 20, 1, 2, 1'b1);
    lvlIn[4] = 1'b0;
    @(negedge clk);
    eoi(20);
    resend();
    expectNone("R4 level deasserted");

    // R4 masked level, R8 recheck, R9 enable
    lvlIn[5] = 1'b1;
    expectNone("R4 level masked");
    doCmd(0, 21, 0, 9);
    expectOffer("R8 level recheck", 21, 0, 9, 1'b1);
    doCmd(2, 21, 0, 0);
    doCmd(1, 21, 0, 0);
    checkEq("R9 disabled prio", int'(rspPrio), 255);
    eoi(21);
    expectNone("R9 disabled level");
    doCmd(3, 21, 0, 0);
    expectOffer("R9 enable level", 21, 0, 9, 1'b1);
    lvlIn[5] = 1'b0;

    // R6 scan pauses while an offer waits
    fire(0);
    expectOffer("R6 blocker", 16, 1, 3, 1'b0);
    reject(17);
    resend();
    repeat (20) @(negedge clk);
    checkEq("R6 paused offNum", int'(offNum), 16);
    offReady = 1'b1;
    @(negedge clk);
    offReady = 1'b0;
    expectOffer("R6 scan resumes", 17, 2, 5, 1'b1);

    // R9 + R3: disable, fire, enable
    doCmd(2, 17, 0, 0);
    fire(1);
    expectNone("R3 disabled edge fire");
    doCmd(3, 17, 0, 0);
    expectOffer("R9 enable edge", 17, 2, 5, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule